// File: doc/BRIEF.md
# Reset sequencer with boot-pin latch

This block turns three reset sources into one active-low reset status line for the rest of the chip. It runs on the reference oscillator clock. The sources are an asynchronous active-low power-on reset, an active-low external warm-reset pin and a one-cycle software warm-reset request. Power-on reset pulls the status line low at once. Every release is timed by a counter: a long hold after power-on, and a shorter hold after a warm or software reset. The external warm-reset pin must stay low for a minimum time before it is accepted, so glitches on the pin do nothing.

The block also captures the boot-mode straps (16 bits) and the emulation-mode straps (2 bits) as power-on reset is released. The captured values stay unchanged as configuration outputs until the next power-on reset. The straps are valid for at least three clock periods before the rising edge of the power-on input. They are not assumed to hold any time after that edge.

The defaults assume a 50 MHz reference clock (20 ns period). The warm-reset assertion delay of at least 960 ns is 48 cycles. The 1200 ns minimum warm-reset pulse is 60 cycles. Each release hold is the stated number of reference periods.

Top module: `rst_seq`

## Requirements
- R1: While `por_n` is low, `rst_stat_n` is low. It goes low asynchronously as soon as `por_n` falls, with no clock edge needed, and this holds in every state.
- R2: After `por_n` rises between two clock edges, `rst_stat_n` is still low after the (POR_CYC+1)th rising edge that follows. It is high after the (POR_CYC+2)th edge: two synchroniser stages, then POR_CYC counted cycles (9195 by default).
- R3: After an accepted warm reset, `rst_stat_n` stays low while `warm_n` is low. It goes high on the (WARM_CYC+2)th rising edge after `warm_n` rises (WARM_CYC is 4040). If `warm_n` goes low again during that count, the count starts again from the later rise.
- R4: In normal operation (`rst_stat_n` high), a high `sw_req` sampled on a rising edge drives `rst_stat_n` low from that edge. The line stays low for exactly SW_CYC clock periods (4040) and then goes high.
- R5: Let TRIP be the larger of WARM_DLY_CYC (48) and WARM_MIN_CYC (60), so 60 by default. In normal operation, a low on `warm_n` lasting at least TRIP periods drives `rst_stat_n` low on the (TRIP+2)th rising edge after the fall, and not before.
- R6: A low pulse on `warm_n` shorter than TRIP clock periods leaves `rst_stat_n` high throughout.
- R7: `boot_cfg` equals the value of `boot_pins` at the last rising clock edge before `por_n` rises. Changes to `boot_pins` at or after the rise of `por_n` are not captured.
- R8: `emu_cfg` equals the value of `emu_pins` at the last rising clock edge before `por_n` rises. It is captured under the same rule as R7.
- R9: A low on `warm_n` has no effect before `rst_stat_n` is first released after a power-on reset. The power-on release time stays as in R2.
- R10: A high on `sw_req` while `rst_stat_n` is low is ignored. The release time of the reset in progress does not change.
- R11: A fall of `por_n` during any warm or software sequence takes priority over it. The full power-on sequence of R2 then restarts from the next rise of `por_n`.
- R12: Warm and software resets never change `boot_cfg` or `emu_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| warm_n | input | 1 | Asynchronous active-low external warm-reset pin |
| sw_req | input | 1 | Software warm-reset request, synchronous to `clk` |
| boot_pins | input | BOOT_W (16) | Boot-mode strap inputs |
| emu_pins | input | EMU_W (2) | Emulation-mode strap inputs |
| rst_stat_n | output | 1 | Active-low reset status |
| boot_cfg | output | BOOT_W (16) | Captured boot-mode configuration |
| emu_cfg | output | EMU_W (2) | Captured emulation-mode configuration |

## Verification
The hardest cases to reach are those where a source arrives while another sequence is already running. These are a warm pulse during the long power-on count, a software request during its own low pulse, a second warm low during the warm release count, and a power-on fall in the middle of a warm hold. The bench reaches each one by driving the new source at a known number of edges into the running count. It then counts edges from the relevant rise to the exact release edge, checking the edge before and the edge of release. Zero-hold strap capture is covered by changing the straps at the same instant `por_n` rises.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int POR_CYC      = 9195,
  parameter int WARM_CYC     = 4040,
  parameter int SW_CYC       = 4040,
  parameter int WARM_DLY_CYC = 48,
  parameter int WARM_MIN_CYC = 60,
  parameter int BOOT_W       = 16,
  parameter int EMU_W        = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              sw_req,
  input  logic [BOOT_W-1:0] boot_pins,
  input  logic [EMU_W-1:0]  emu_pins,
  output logic              rst_stat_n,
  output logic [BOOT_W-1:0] boot_cfg,
  output logic [EMU_W-1:0]  emu_cfg
);

  localparam int TRIP   = (WARM_DLY_CYC > WARM_MIN_CYC) ? WARM_DLY_CYC : WARM_MIN_CYC;
  localparam int REL_A  = (WARM_CYC > SW_CYC) ? WARM_CYC : SW_CYC;
  localparam int REL_MX = (POR_CYC > REL_A) ? POR_CYC : REL_A;
  localparam int CW     = $clog2(REL_MX + 1);
  localparam int LW     = $clog2(TRIP + 1);

  typedef enum logic [1:0] {S_POR, S_RUN, S_WARM, S_SW} st_t;

  st_t               state, state_nxt;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic [LW-1:0]     low_cnt;
  logic [1:0]        por_sync, warm_sync;
  logic [BOOT_W-1:0] boot_d;
  logic [EMU_W-1:0]  emu_d;
  logic              stat_q;

  wire por_rel  = por_sync[1];
  wire warm_low = !warm_sync[1];
  wire armed    = (state == S_RUN) || (state == S_SW);
  wire trip     = armed && warm_low && (low_cnt == LW'(TRIP - 1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) por_sync <= 2'b00;
    else        por_sync <= {por_sync[0], 1'b1};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) warm_sync <= 2'b11;
    else        warm_sync <= {warm_sync[0], warm_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                low_cnt <= '0;
    else if (armed && warm_low) low_cnt <= low_cnt + 1'b1;
    else                       low_cnt <= '0;

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    case (state)
      S_POR:
        if (por_rel) begin
          if (cnt == CW'(POR_CYC - 1)) begin
            state_nxt = S_RUN;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + 1'b1;
          end
        end
      S_RUN:
        if (trip) begin
          state_nxt = S_WARM;
          cnt_nxt   = '0;
        end else if (sw_req) begin
          state_nxt = S_SW;
          cnt_nxt   = '0;
        end
      S_SW:
        if (trip) begin
          state_nxt = S_WARM;
          cnt_nxt   = '0;
        end else if (cnt == CW'(SW_CYC - 1)) begin
          state_nxt = S_RUN;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      S_WARM:
        if (warm_low) begin
          cnt_nxt = '0;
        end else if (cnt == CW'(WARM_CYC - 1)) begin
          state_nxt = S_RUN;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      default: begin
        state_nxt = S_POR;
        cnt_nxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      state  <= S_POR;
      cnt    <= '0;
      stat_q <= 1'b0;
    end else begin
      state  <= state_nxt;
      cnt    <= cnt_nxt;
      stat_q <= (state_nxt == S_RUN);
    end

  assign rst_stat_n = stat_q;

  always_ff @(posedge clk) begin
    boot_d <= boot_pins;
    emu_d  <= emu_pins;
  end

  always_ff @(posedge clk)
    if (!por_sync[0]) begin
      boot_cfg <= boot_d;
      emu_cfg  <= emu_d;
    end

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int REL_MIN = 4040,
  parameter int BOOT_W  = 16,
  parameter int EMU_W   = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              sw_req,
  input logic              rst_stat_n,
  input logic [BOOT_W-1:0] boot_cfg,
  input logic [EMU_W-1:0]  emu_cfg
);

  localparam int RW = $clog2(REL_MIN + 2);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                            low_run <= '0;
    else if (rst_stat_n)                   low_run <= '0;
    else if (low_run != RW'(REL_MIN + 1))  low_run <= low_run + 1'b1;

  always @(posedge clk)
    if (!por_n) p_por_forces_low_r1: assert (!rst_stat_n);

  p_sw_drops_status_r4: assert property (@(posedge clk) disable iff (!por_n)
    (sw_req && rst_stat_n) |=> !rst_stat_n);

  p_min_low_time_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_stat_n) |-> (low_run >= RW'(REL_MIN)));

  p_boot_cfg_held_r12: assert property (@(posedge clk) disable iff (!por_n)
    rst_stat_n |=> $stable(boot_cfg));

  p_emu_cfg_held_r12: assert property (@(posedge clk) disable iff (!por_n)
    rst_stat_n |=> $stable(emu_cfg));

endmodule

bind rst_seq rst_seq_chk #(
  .REL_MIN((WARM_CYC < SW_CYC) ? WARM_CYC : SW_CYC),
  .BOOT_W (BOOT_W),
  .EMU_W  (EMU_W)
) i_rst_seq_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sw_req    (sw_req),
  .rst_stat_n(rst_stat_n),
  .boot_cfg  (boot_cfg),
  .emu_cfg   (emu_cfg)
);

// File: tb/test_rst_seq.sv
`timescale 1ns/1ps
module test_rst_seq;

  localparam int POR_CYC  = 9195;
  localparam int WARM_CYC = 4040;
  localparam int SW_CYC   = 4040;
  localparam int TRIP     = 60;

  logic        clk = 1'b0;
  logic        por_n = 1'b1;
  logic        warm_n = 1'b1;
  logic        sw_req = 1'b0;
  logic [15:0] boot_pins = 16'h0000;
  logic [1:0]  emu_pins = 2'b00;
  logic        rst_stat_n;
  logic [15:0] boot_cfg;
  logic [1:0]  emu_cfg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_seq i_rst_seq (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .sw_req(sw_req),
    .boot_pins(boot_pins), .emu_pins(emu_pins),
    .rst_stat_n(rst_stat_n), .boot_cfg(boot_cfg), .emu_cfg(emu_cfg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic por_release(input logic [15:0] b, input logic [1:0] e, input string req);
    @(negedge clk);
    por_n = 1'b1;
    boot_pins = ~b;
    emu_pins = ~e;
    step(POR_CYC + 1);
    chk(rst_stat_n == 1'b0, req, rst_stat_n, 0);
    step(1);
    chk(rst_stat_n == 1'b1, req, rst_stat_n, 1);
    chk(boot_cfg == b, "R7 boot capture", boot_cfg, b);
    chk(emu_cfg == e, "R8 emu capture", emu_cfg, e);
  endtask

  task automatic t_power_on;
    #3 por_n = 1'b0;
    #1 chk(rst_stat_n == 1'b0, "R1 async assert", rst_stat_n, 0);
    boot_pins = 16'hA5C3;
    emu_pins = 2'b10;
    step(6);
    chk(rst_stat_n == 1'b0, "R1 held low", rst_stat_n, 0);
    por_release(16'hA5C3, 2'b10, "R2 por release");
  endtask

  task automatic t_warm_short;
    bit seen = 1'b0;
    @(negedge clk);
    warm_n = 1'b0;
    for (int i = 0; i < TRIP + 20; i++) begin
      @(negedge clk);
      if (i + 1 == TRIP - 1) warm_n = 1'b1;
      if (!rst_stat_n) seen = 1'b1;
    end
    chk(!seen, "R6 short warm pulse ignored", seen, 0);
  endtask

  task automatic t_warm_accept;
    boot_pins = 16'h1234;
    emu_pins = 2'b01;
    @(negedge clk);
    warm_n = 1'b0;
    step(TRIP + 1);
    chk(rst_stat_n == 1'b1, "R5 not before trip", rst_stat_n, 1);
    step(1);
    chk(rst_stat_n == 1'b0, "R5 warm trip", rst_stat_n, 0);
    repeat (100) @(negedge clk);
    warm_n = 1'b1;
    step(WARM_CYC + 1);
    chk(rst_stat_n == 1'b0, "R3 warm hold", rst_stat_n, 0);
    step(1);
    chk(rst_stat_n == 1'b1, "R3 warm release", rst_stat_n, 1);
    chk(boot_cfg == 16'hA5C3, "R12 boot kept", boot_cfg, 16'hA5C3);
    chk(emu_cfg == 2'b10, "R12 emu kept", emu_cfg, 2);
  endtask

  task automatic t_warm_restart;
    @(negedge clk);
    warm_n = 1'b0;
    repeat (TRIP + 20) @(negedge clk);
    warm_n = 1'b1;
    repeat (1000) @(negedge clk);
    warm_n = 1'b0;
    repeat (10) @(negedge clk);
    warm_n = 1'b1;
    step(WARM_CYC + 1);
    chk(rst_stat_n == 1'b0, "R3 restart hold", rst_stat_n, 0);
    step(1);
    chk(rst_stat_n == 1'b1, "R3 restart release", rst_stat_n, 1);
  endtask

  task automatic t_sw_pulse;
    @(negedge clk);
    sw_req = 1'b1;
    step(1);
    chk(rst_stat_n == 1'b0, "R4 sw assert", rst_stat_n, 0);
    repeat (500) @(posedge clk);
    @(negedge clk);
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    step(SW_CYC - 502);
    chk(rst_stat_n == 1'b0, "R10 sw pulse width kept", rst_stat_n, 0);
    step(1);
    chk(rst_stat_n == 1'b1, "R4 sw release", rst_stat_n, 1);
    step(5);
    chk(rst_stat_n == 1'b1, "R10 ignored request left no pulse", rst_stat_n, 1);
  endtask

  task automatic t_warm_during_por;
    @(posedge clk);
    #5 por_n = 1'b0;
    #1 chk(rst_stat_n == 1'b0, "R1 async mid-cycle", rst_stat_n, 0);
    boot_pins = 16'h7E01;
    emu_pins = 2'b11;
    step(10);
    @(negedge clk);
    por_n = 1'b1;
    boot_pins = 16'h0000;
    emu_pins = 2'b00;
    step(100);
    @(negedge clk);
    warm_n = 1'b0;
    repeat (200) @(negedge clk);
    warm_n = 1'b1;
    step(POR_CYC + 1 - 300);
    chk(rst_stat_n == 1'b0, "R9 por hold unaffected", rst_stat_n, 0);
    step(1);
    chk(rst_stat_n == 1'b1, "R9 por release on time", rst_stat_n, 1);
    chk(boot_cfg == 16'h7E01, "R7 second capture", boot_cfg, 16'h7E01);
    chk(emu_cfg == 2'b11, "R8 second capture", emu_cfg, 3);
  endtask

  task automatic t_por_over_warm;
    @(negedge clk);
    warm_n = 1'b0;
    step(TRIP + 10);
    chk(rst_stat_n == 1'b0, "R11 warm active", rst_stat_n, 0);
    #4 por_n = 1'b0;
    warm_n = 1'b1;
    boot_pins = 16'hBEEF;
    emu_pins = 2'b01;
    step(20);
    chk(rst_stat_n == 1'b0, "R11 por overrides warm", rst_stat_n, 0);
    por_release(16'hBEEF, 2'b01, "R11 por restart");
  endtask

  initial begin
    t_power_on();
    t_warm_short();
    t_warm_accept();
    t_warm_restart();
    t_sw_pulse();
    t_warm_during_por();
    t_por_over_warm();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule